// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block buffers playback samples for one channel of an audio-codec serial link. Software or a DMA engine writes 32-bit words. Each word is turned into one or two samples, and every sample is stored as a 20-bit word aligned to the left. The codec side takes the samples out as left/right pairs over a valid/ready handshake, at most one pair per clock.

A 6-bit control word sets the following:
- the transmit enable,
- two slot-select bits,
- a 2-bit sample-size code,
- a request for compact packing, where two 16-bit halves travel in one write.

A separate interface-enable write with the enable bit at 0 empties the FIFO and clears the configuration.

Draining only starts once the FIFO is at least half full. It then continues as a burst until fewer than two samples remain or the codec refuses a pair. Four status flags (empty, half-empty, full, underrun) are set and cleared by push and drain events, not decoded from the level. Software sees them the same way it would see a register.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the flags read empty=1, half=1, full=0 and underrun=0, and pair_valid is 0. The control state is all zeros: disabled, no slot selected, size code 0, non-compact.
- R2: Control word bits are [0] enable, [1] slot 3, [2] slot 4, [4:3] size code and [5] compact request. Size code 0 means 16 bits, 1 means 18, 2 means 20 and 3 means 12. In non-compact mode a write stores (wr_data << s) masked to 20 bits, where s is 4, 2, 0 and 8 for codes 0, 1, 2 and 3.
- R3: In compact mode a write stores two samples: first wr_data[15:0], then wr_data[31:16]. Each half is shifted left by 8 for code 3, or by 4 otherwise, and masked to 20 bits. A compact request made together with code 1 or code 2 is forced to non-compact.
- R4: A non-compact write is accepted only while level < DEPTH. A compact write is accepted only while level + 2 < DEPTH. A refused write is dropped and changes neither the contents nor the flags.
- R5: pair_valid is 1 only when all of these hold: enable is set, slot 3 or slot 4 is set, and level >= 2. In addition, either level >= DEPTH/2 or a burst is in progress. pair_data carries the older sample in [39:20] and the next sample in [19:0]. A pair leaves on a cycle with valid and ready both high.
- R6: After a pop that leaves at least 2 samples, the burst continues below DEPTH/2. The burst ends when a pop leaves fewer than 2 samples, when valid is high with ready low, or when the transmit gate is closed. An odd last sample stays in the FIFO.
- R7: After an accepted push, a level above 0 clears empty and underrun. A level >= DEPTH/2 clears half. A level of DEPTH sets full.
- R8: After a pop, full clears. A level <= DEPTH/2 sets half. A level of 0 sets empty and underrun.
- R9: A cycle with if_we=1 and if_en=0 empties the FIFO, restores the flags and control state of R1, and overrides any push or control write in the same cycle.
- R10: When a push and a pop fall in the same cycle, the flags use the net level. The push rules are applied first and the pop rules second.
- R11: A control write affects packing, gating and draining from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word (enable, slots, size code, compact) |
| if_we | input | 1 | Interface-enable write strobe |
| if_en | input | 1 | Interface-enable value; 0 flushes |
| wr_valid | input | 1 | Sample word write strobe |
| wr_data | input | 32 | Sample word |
| pair_valid | output | 1 | A stereo pair is offered to the codec |
| pair_data | output | 40 | Left sample [39:20], right sample [19:0] |
| pair_ready | input | 1 | Codec accepts the offered pair |
| flag_empty | output | 1 | Empty flag |
| flag_half | output | 1 | Half-empty flag |
| flag_full | output | 1 | Full flag |
| flag_underrun | output | 1 | Underrun flag |

## Verification
pair_valid and pair_data depend only on registered state, so they are valid in the cycle after the edge that changed that state. The bench therefore compares them 1 ns after it drives the inputs, before the next edge. The flags, the level and the stored data move on the edge that takes a push, a pop or a flush. A control write takes effect one edge later, so the cycle that carries it still behaves under the old setting. Every cycle runs through one task that drives the inputs, checks the pair outputs against a queue model, and then lets the edge pass. After the edge the task updates the model and compares all four flags, so no check depends on the order of events at the edge.

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [5:0]  ctl_wdata,
  input  logic        if_we,
  input  logic        if_en,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        pair_valid,
  output logic [39:0] pair_data,
  input  logic        pair_ready,
  output logic        flag_empty,
  output logic        flag_half,
  output logic        flag_full,
  output logic        flag_underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
  localparam logic [LW-1:0] TWO_L   = LW'(2);
  localparam logic [LW:0]   DEPTH_X = (LW+1)'(DEPTH);

  logic [19:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] level, level_net, push_cnt;
  logic          en_q, s3_q, s4_q, cmp_q, burst_q;
  logic [1:0]    size_q;
  logic          flush, go, push_ok, pop;
  logic [19:0]   nc_s, lo_s, hi_s;
  logic          e_n, h_n, f_n, u_n, burst_n;

  assign flush = if_we & ~if_en;
  assign go    = en_q & (s3_q | s4_q);

  always_comb begin
    case (size_q)
      2'd0:    nc_s = {wr_data[15:0], 4'h0};
      2'd1:    nc_s = {wr_data[17:0], 2'b00};
      2'd2:    nc_s = wr_data[19:0];
      default: nc_s = {wr_data[11:0], 8'h00};
    endcase
  end

  assign lo_s = (size_q == 2'd3) ? {wr_data[11:0], 8'h00}  : {wr_data[15:0], 4'h0};
  assign hi_s = (size_q == 2'd3) ? {wr_data[27:16], 8'h00} : {wr_data[31:16], 4'h0};

  assign push_ok = wr_valid & ~flush &
                   (cmp_q ? (({1'b0, level} + (LW+1)'(2)) < DEPTH_X) : (level < DEPTH_L));
  assign push_cnt = !push_ok ? '0 : (cmp_q ? TWO_L : LW'(1));

  assign pair_valid = go & (level >= TWO_L) & (burst_q | (level >= HALF_L));
  assign pop        = pair_valid & pair_ready;
  assign pair_data  = {mem[rptr], mem[rptr + AW'(1)]};
  assign level_net  = level + push_cnt - (pop ? TWO_L : '0);

  always_comb begin
    e_n = flag_empty;
    h_n = flag_half;
    f_n = flag_full;
    u_n = flag_underrun;
    if (push_ok) begin
      if (level_net != '0) begin
        e_n = 1'b0;
        u_n = 1'b0;
      end
      if (level_net >= HALF_L) h_n = 1'b0;
      if (level_net >= DEPTH_L) f_n = 1'b1;
    end
    if (pop) begin
      f_n = 1'b0;
      if (level_net <= HALF_L) h_n = 1'b1;
      if (level_net == '0) begin
        e_n = 1'b1;
        u_n = 1'b1;
      end
    end
    if (!go)                             burst_n = 1'b0;
    else if (pop)                        burst_n = (level_net >= TWO_L);
    else if (pair_valid && !pair_ready)  burst_n = 1'b0;
    else                                 burst_n = burst_q;
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      if (cmp_q) begin
        mem[wptr]          <= lo_s;
        mem[wptr + AW'(1)] <= hi_s;
      end else begin
        mem[wptr] <= nc_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0; wptr <= '0; rptr <= '0; burst_q <= 1'b0;
      flag_empty <= 1'b1; flag_half <= 1'b1; flag_full <= 1'b0; flag_underrun <= 1'b0;
      en_q <= 1'b0; s3_q <= 1'b0; s4_q <= 1'b0; size_q <= 2'd0; cmp_q <= 1'b0;
    end else if (flush) begin
      level <= '0; wptr <= '0; rptr <= '0; burst_q <= 1'b0;
      flag_empty <= 1'b1; flag_half <= 1'b1; flag_full <= 1'b0; flag_underrun <= 1'b0;
      en_q <= 1'b0; s3_q <= 1'b0; s4_q <= 1'b0; size_q <= 2'd0; cmp_q <= 1'b0;
    end else begin
      level         <= level_net;
      wptr          <= wptr + AW'(push_cnt);
      if (pop) rptr <= rptr + AW'(2);
      burst_q       <= burst_n;
      flag_empty    <= e_n;
      flag_half     <= h_n;
      flag_full     <= f_n;
      flag_underrun <= u_n;
      if (ctl_we) begin
        en_q   <= ctl_wdata[0];
        s3_q   <= ctl_wdata[1];
        s4_q   <= ctl_wdata[2];
        size_q <= ctl_wdata[4:3];
        cmp_q  <= ctl_wdata[5] & ((ctl_wdata[4:3] == 2'd0) | (ctl_wdata[4:3] == 2'd3));
      end
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L);
  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && level == DEPTH_L && !pop && !flush) |=> level == DEPTH_L);
  p_full_is_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full == (level == DEPTH_L));
  p_empty_is_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_empty == (level == '0));
  p_underrun_in_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underrun |-> flag_empty);
  p_pair_has_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (level >= TWO_L && go));
  p_pop_takes_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_ok && !flush) |=> level == $past(level) - TWO_L);
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && flag_empty && flag_half && !flag_full && !flag_underrun && !pair_valid));
endmodule

// File: tb/audio_tx_fifo_tb.sv
module audio_tx_fifo_tb;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, if_we = 1'b0, if_en = 1'b0, wr_valid = 1'b0, pair_ready = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic [31:0] wr_data = '0;
  logic        pair_valid, flag_empty, flag_half, flag_full, flag_underrun;
  logic [39:0] pair_data;

  audio_tx_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .if_we(if_we), .if_en(if_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .pair_valid(pair_valid), .pair_data(pair_data), .pair_ready(pair_ready),
    .flag_empty(flag_empty), .flag_half(flag_half), .flag_full(flag_full),
    .flag_underrun(flag_underrun)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  string cur = "R1";
  logic [31:0] seed = 32'h1d2c3b4a;

  logic [19:0] q[$];
  bit me = 1, mh = 1, mf = 0, mu = 0, mb = 0;
  bit c_en = 0, c_s3 = 0, c_s4 = 0, c_cmp = 0;
  int c_size = 0;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", cur, what, act, exp);
    end
  endtask

  function automatic bit mvalid();
    return c_en && (c_s3 || c_s4) && q.size() >= 2 && (mb || q.size() >= HALF);
  endfunction

  function automatic logic [19:0] fit(input logic [31:0] v, input int sh);
    return 20'((v << sh) & 32'hFFFFF);
  endfunction

  task automatic model_edge(input bit cw, input logic [5:0] cd, input bit iw, input bit ie,
                            input bit wv, input logic [31:0] wd, input bit rdy, input bit ev);
    bit pop, go, acc;
    int l, n, sh;
    pop = ev && rdy;
    go  = c_en && (c_s3 || c_s4);
    if (iw && !ie) begin
      q.delete();
      me = 1; mh = 1; mf = 0; mu = 0; mb = 0;
      c_en = 0; c_s3 = 0; c_s4 = 0; c_size = 0; c_cmp = 0;
      return;
    end
    l = q.size();
    acc = wv && (c_cmp ? (l + 2 < DEPTH) : (l < DEPTH));
    if (acc) begin
      if (c_cmp) begin
        sh = (c_size == 3) ? 8 : 4;
        q.push_back(fit(wd & 32'hFFFF, sh));
        q.push_back(fit(wd >> 16, sh));
      end else begin
        sh = (c_size == 0) ? 4 : (c_size == 1) ? 2 : (c_size == 2) ? 0 : 8;
        q.push_back(fit(wd, sh));
      end
    end
    if (pop) begin
      void'(q.pop_front());
      void'(q.pop_front());
    end
    n = q.size();
    if (acc) begin
      if (n > 0) begin me = 0; mu = 0; end
      if (n >= HALF) mh = 0;
      if (n >= DEPTH) mf = 1;
    end
    if (pop) begin
      mf = 0;
      if (n <= HALF) mh = 1;
      if (n == 0) begin me = 1; mu = 1; end
    end
    if (!go) mb = 0;
    else if (pop) mb = (n >= 2);
    else if (ev && !rdy) mb = 0;
    if (cw) begin
      c_en = cd[0]; c_s3 = cd[1]; c_s4 = cd[2]; c_size = int'(cd[4:3]);
      c_cmp = cd[5] && (cd[4:3] == 2'd0 || cd[4:3] == 2'd3);
    end
  endtask

  task automatic cyc(input bit cw, input logic [5:0] cd, input bit iw, input bit ie,
                     input bit wv, input logic [31:0] wd, input bit rdy);
    bit ev;
    ctl_we = cw; ctl_wdata = cd; if_we = iw; if_en = ie;
    wr_valid = wv; wr_data = wd; pair_ready = rdy;
    #1;
    ev = mvalid();
    chk("R5 pair_valid", longint'(pair_valid), longint'(ev));
    if (ev && pair_valid)
      chk("R2/R3 pair_data", longint'(pair_data), (longint'(q[0]) << 20) | longint'(q[1]));
    @(posedge clk);
    model_edge(cw, cd, iw, ie, wv, wd, rdy, ev);
    #1;
    chk("R7/R8 empty", longint'(flag_empty), longint'(me));
    chk("R7/R8 half", longint'(flag_half), longint'(mh));
    chk("R7/R8 full", longint'(flag_full), longint'(mf));
    chk("R8 underrun", longint'(flag_underrun), longint'(mu));
  endtask

  task automatic push(input bit rdy);      cyc(0, '0, 0, 0, 1, rnd(), rdy); endtask
  task automatic idle(input bit rdy);      cyc(0, '0, 0, 0, 0, '0, rdy); endtask
  task automatic ctl(input logic [5:0] w); cyc(1, w, 0, 0, 0, '0, 0); endtask
  task automatic flush();                  cyc(0, '0, 1, 0, 0, '0, 0); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1 empty", longint'(flag_empty), 1);
    chk("R1 half", longint'(flag_half), 1);
    chk("R1 full", longint'(flag_full), 0);
    chk("R1 underrun", longint'(flag_underrun), 0);
    chk("R1 pair_valid", longint'(pair_valid), 0);
    @(posedge clk); #1;
    // R1: control cleared, so a full FIFO must not drain
    for (int i = 0; i < DEPTH + 1; i++) push(1);
    cur = "R11";
    ctl(6'b000011);
    for (int i = 0; i < 6; i++) idle(1);
    cur = "R9";
    for (int i = 0; i < 5; i++) push(0);
    cyc(1, 6'b000111, 1, 0, 1, rnd(), 1);
    idle(1);
    cyc(0, '0, 1, 1, 0, '0, 0);
    // R2 and R3 sweep over size codes, packing and slot choices
    for (int code = 0; code < 4; code++) begin
      for (int cm = 0; cm < 2; cm++) begin
        logic [1:0] sl;
        cur = cm ? "R3" : "R2";
        sl = 2'((code + cm) % 3);
        if (sl == 0) sl = 2'b11;
        flush();
        ctl({1'(cm), 2'(code), sl, 1'b1});
        for (int i = 0; i < DEPTH + 2; i++) push(0);
        for (int i = 0; i < DEPTH + 2; i++) idle(1);
      end
    end
    cur = "R4";
    flush();
    ctl(6'b100011);
    for (int i = 0; i < 5; i++) push(0);
    ctl(6'b000011);
    for (int i = 0; i < 4; i++) push(0);
    for (int i = 0; i < DEPTH; i++) idle(1);
    cur = "R6";
    flush();
    ctl(6'b000101);
    for (int i = 0; i < DEPTH; i++) push(0);
    idle(1); idle(1); idle(1); idle(0); idle(1); idle(1); idle(1);
    flush();
    ctl(6'b000011);
    for (int i = 0; i < 5; i++) push(0);
    for (int i = 0; i < 4; i++) idle(1);
    for (int i = 0; i < 7; i++) push(0);
    idle(1);
    ctl(6'b000010);
    idle(1); idle(1);
    cur = "R10";
    flush();
    ctl(6'b000011);
    for (int i = 0; i < 4; i++) push(0);
    push(1); push(1); push(1); push(1); idle(1); idle(1);
    cur = "R7";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = rnd();
      if (r[9:0] == 10'd3)       flush();
      else if (r[5:0] == 6'd5)   ctl(6'(r[21:16]) | 6'b000001);
      else cyc(0, '0, 0, 0, r[1] | r[2], rnd(), r[3]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule